// File: doc/BRIEF.md
# Fractional-Period Sample Clock Generator

This block turns a fast reference clock into a train of single-cycle sample strobes. The average spacing of the strobes is a fixed-point number of reference clocks: a 16-bit whole part and a 16-bit fraction. A host writes the two parts into separate holding registers. A 16-bit down-counter counts out the whole part. A fraction accumulator, which is never cleared by register writes, adds one extra clock to a period each time it carries. Over many periods the mean spacing therefore resolves to 1/65536 of a reference clock.

Periods are handed to the counter in blocks of four strobes. One reload value covers all four strobes of a block. A host write that lands inside a block is held until the next block starts. The block also keeps a free-running 8-bit count of strobes, used as a timestamp, and a 4-bit message sequence number taken from the top of that count. Both move in the same cycle that the strobe is high. The loop filter that chooses the period sits outside this block.

Top module: `frac_sample_clk`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `sample_stb` is 0, `stamp` is 0 and `seq_num` is 0. Reset loads the whole-part register with parameter `RST_INT` (default 16), loads the fraction register with 0, and sets the fraction accumulator to 0.
- R2: `sample_stb` is never high for two consecutive cycles.
- R3: At each block start, the 16-bit fraction register is added to the 16-bit accumulator. The accumulator keeps the low 16 bits of the sum. The spacing for that block is the effective whole part plus the carry-out of the addition. The first block starts at the first clock edge after reset is released, and its first strobe is high in cycle L+1 after release, where L is that block's spacing.
- R4: Each block holds exactly four strobes, all at the same spacing. The next block starts at the edge that raises the fourth strobe.
- R5: A write to the whole-part or fraction register has no effect on the strobes that remain in the current block. It first applies at the next block start.
- R6: Writing the period registers does not clear the fraction accumulator. Its carry sequence continues across a change of fraction value.
- R7: A whole part of 0 or 1 is treated as 2.
- R8: `stamp` goes up by one, modulo 256, in the same cycle that `sample_stb` is high. It does not change in any other cycle. It wraps from 255 to 0.
- R9: `seq_num` equals bits [7:4] of `stamp` and changes only in strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_we | input | 1 | Write strobe for the whole-part register |
| int_wdata | input | 16 | New whole-part value, in reference clocks |
| frac_we | input | 1 | Write strobe for the fraction register |
| frac_wdata | input | 16 | New fraction value, in units of 1/65536 clock |
| sample_stb | output | 1 | One-cycle sample strobe |
| stamp | output | 8 | Strobe count timestamp |
| seq_num | output | 4 | Message sequence number |

## Verification
The hardest case to reach from the ports is a host write that lands in the middle of a block while the accumulator already holds a partial sum. A wrong design would then show a period one clock off, and only for one block. The bench writes new values one cycle after chosen strobes, both at a block's first strobe and at other points in a block. It checks every strobe spacing against its own running model of the accumulator. The table of period vectors mixes fractions that carry every block, some blocks or never, and includes whole parts below the clamp. A long run at the minimum period then drives the timestamp through its wrap.

// File: rtl/fsc_pkg.sv
// Package of shared widths and the period word type.
// Assumes a 16-bit whole part and a 16-bit fraction part.
package fsc_pkg;
    parameter int INT_W  = 16;
    parameter int FRAC_W = 16;

    typedef logic [INT_W-1:0]  int_t;
    typedef logic [FRAC_W-1:0] frac_t;

    // Whole and fractional parts of the desired sample period.
    typedef struct packed {
        int_t  whole;
        frac_t part;
    } period_t;
endpackage

// File: rtl/fsc_period_regs.sv
// Holding registers for the desired period, written by the host.
// Each part has its own write strobe. The values are only sampled by the
// reload logic at block starts, so they may change at any time.
module fsc_period_regs
    import fsc_pkg::*;
#(
    parameter int RST_INT = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  int_we,
    input  int_t  int_wdata,
    input  logic  frac_we,
    input  frac_t frac_wdata,
    output period_t held
);
    // Capture host writes; reset gives the default period and a zero fraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held.whole <= int_t'(RST_INT);
            held.part  <= '0;
        end else begin
            if (int_we)  held.whole <= int_wdata;
            if (frac_we) held.part  <= frac_wdata;
        end
    end
endmodule

// File: rtl/fsc_reload_calc.sv
// Reload value calculator and fraction accumulator.
// Clamps the whole part to MIN_PERIOD. Adds the fraction into a running
// accumulator and extends the period by one clock on carry-out. The
// accumulator advances only when the timer asks for a reload. No register
// write clears it; only the chip reset does.
module fsc_reload_calc
    import fsc_pkg::*;
#(
    parameter int MIN_PERIOD = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    reload,
    input  period_t held,
    output int_t    len_m1
);
    localparam int_t MIN_V = int_t'(MIN_PERIOD);

    frac_t            acc_q;
    logic [FRAC_W:0]  sum;
    int_t             eff;

    // Next accumulator sum, clamped whole part and reload length minus one.
    always_comb begin
        sum    = {1'b0, acc_q} + {1'b0, held.part};
        eff    = (held.whole < MIN_V) ? MIN_V : held.whole;
        len_m1 = eff - int_t'(1) + int_t'(sum[FRAC_W]);
    end

    // Advance the accumulator once per block start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (reload) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fsc_sample_timer.sv
// Down-counter that times the sample strobes.
// Counts out one period per strobe and reuses the held reload value for
// BLK_SAMPLES strobes. It asks for a new value at the first edge after reset
// and at the edge that issues the last strobe of a block. Assumes the
// supplied length minus one is at least 1.
module fsc_sample_timer
    import fsc_pkg::*;
#(
    parameter int BLK_SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  int_t len_m1,
    output logic reload,
    output logic expire,
    output logic sample_stb
);
    localparam int BLK_W = (BLK_SAMPLES > 1) ? $clog2(BLK_SAMPLES) : 1;
    localparam logic [BLK_W-1:0] LAST = BLK_W'(BLK_SAMPLES - 1);

    int_t             cnt_q;
    int_t             hold_q;
    logic [BLK_W-1:0] blk_q;
    logic             started_q;

    // Expiry and block-boundary reload requests.
    always_comb begin
        expire = started_q && (cnt_q == '0);
        reload = !started_q || (expire && (blk_q == LAST));
    end

    // Counter, block position and registered strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            hold_q     <= '0;
            blk_q      <= '0;
            started_q  <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= expire;
            if (reload) begin
                cnt_q     <= len_m1;
                hold_q    <= len_m1;
                blk_q     <= '0;
                started_q <= 1'b1;
            end else if (expire) begin
                cnt_q <= hold_q;
                blk_q <= blk_q + 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsc_stamp.sv
// Timestamp counter and sequence number.
// Advances on the edge that raises the sample strobe, so the new count is
// visible in the strobe cycle. Wraps naturally. The sequence number is the
// top SEQ_W bits of the count.
module fsc_stamp #(
    parameter int STAMP_W = 8,
    parameter int SEQ_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic [STAMP_W-1:0] stamp,
    output logic [SEQ_W-1:0]   seq_num
);
    // Count strobes modulo 2**STAMP_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp <= '0;
        end else if (tick) begin
            stamp <= stamp + 1'b1;
        end
    end

    // Take the sequence number from the high bits.
    always_comb seq_num = stamp[STAMP_W-1 -: SEQ_W];
endmodule

// File: rtl/frac_sample_clk.sv
// Top level of the fractional-period sample clock generator.
// Connects the period registers, the reload calculator, the strobe timer
// and the timestamp counter. Assumes a synchronous active-low reset.
module frac_sample_clk
    import fsc_pkg::*;
#(
    parameter int RST_INT     = 16,
    parameter int MIN_PERIOD  = 2,
    parameter int BLK_SAMPLES = 4,
    parameter int STAMP_W     = 8,
    parameter int SEQ_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               int_we,
    input  logic [INT_W-1:0]   int_wdata,
    input  logic               frac_we,
    input  logic [FRAC_W-1:0]  frac_wdata,
    output logic               sample_stb,
    output logic [STAMP_W-1:0] stamp,
    output logic [SEQ_W-1:0]   seq_num
);
    period_t held;
    int_t    len_m1;
    logic    reload;
    logic    expire;

    fsc_period_regs #(.RST_INT(RST_INT)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_we     (int_we),
        .int_wdata  (int_wdata),
        .frac_we    (frac_we),
        .frac_wdata (frac_wdata),
        .held       (held)
    );

    fsc_reload_calc #(.MIN_PERIOD(MIN_PERIOD)) u_calc (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .held   (held),
        .len_m1 (len_m1)
    );

    fsc_sample_timer #(.BLK_SAMPLES(BLK_SAMPLES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_m1     (len_m1),
        .reload     (reload),
        .expire     (expire),
        .sample_stb (sample_stb)
    );

    fsc_stamp #(.STAMP_W(STAMP_W), .SEQ_W(SEQ_W)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (expire),
        .stamp   (stamp),
        .seq_num (seq_num)
    );
endmodule

// File: rtl/fsc_checker.sv
// Property checker for frac_sample_clk, attached with bind.
// Watches only the top-level ports. Keeps its own interval counters to
// compare strobe spacings inside a block.
module fsc_checker #(
    parameter int STAMP_W     = 8,
    parameter int SEQ_W       = 4,
    parameter int BLK_SAMPLES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_stb,
    input logic [STAMP_W-1:0] stamp,
    input logic [SEQ_W-1:0]   seq_num
);
    logic [17:0] intv_q;
    logic [17:0] last_intv_q;
    int          pos_q;

    // Measure the cycles between strobes and the position within a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_q      <= '0;
            last_intv_q <= '0;
            pos_q       <= 0;
        end else if (sample_stb) begin
            intv_q      <= 18'd1;
            last_intv_q <= intv_q;
            pos_q       <= (pos_q == BLK_SAMPLES - 1) ? 0 : pos_q + 1;
        end else if (intv_q != '1) begin
            intv_q <= intv_q + 1'b1;
        end
    end

    // R2: a strobe lasts one cycle.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R4: spacing stays the same within a block.
    a_r4_block_constant: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && pos_q >= 2) |-> (intv_q == last_intv_q));

    // R8: the timestamp steps by one with each strobe.
    a_r8_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (stamp == STAMP_W'($past(stamp) + 1'b1)));

    // R8: the timestamp holds between strobes.
    a_r8_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(stamp));

    // R9: the sequence number moves only in strobe cycles.
    a_r9_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(seq_num));
endmodule

bind frac_sample_clk fsc_checker #(
    .STAMP_W     (STAMP_W),
    .SEQ_W       (SEQ_W),
    .BLK_SAMPLES (BLK_SAMPLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .stamp      (stamp),
    .seq_num    (seq_num)
);

// File: tb/frac_sample_clk_tb.sv
module frac_sample_clk_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RST_INT    = 16;
    localparam int NVEC       = 7;
    // {whole, fraction, blocks to run}
    localparam logic [39:0] VECS [0:NVEC-1] = '{
        {16'd5,  16'h8000, 8'd3},
        {16'd3,  16'h4000, 8'd4},
        {16'd1,  16'hC000, 8'd3},
        {16'd0,  16'h0000, 8'd2},
        {16'd7,  16'hFFFF, 8'd4},
        {16'd10, 16'h0001, 8'd2},
        {16'd2,  16'h0000, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_we = 1'b0;
    logic [15:0] int_wdata = '0;
    logic        frac_we = 1'b0;
    logic [15:0] frac_wdata = '0;
    logic        sample_stb;
    logic [7:0]  stamp;
    logic [3:0]  seq_num;

    int          checks = 0;
    int          fails = 0;
    int          n_stb = 0;
    int          gap = 0;
    int          last_gap = 0;
    int          m_len = 0;
    logic [15:0] m_acc = '0;
    logic [15:0] p_int = 16'(RST_INT);
    logic [15:0] p_frac = '0;
    string       cur_tag = "R3";

    frac_sample_clk u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_we     (int_we),
        .int_wdata  (int_wdata),
        .frac_we    (frac_we),
        .frac_wdata (frac_wdata),
        .sample_stb (sample_stb),
        .stamp      (stamp),
        .seq_num    (seq_num)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (strobe %0d)", req, act, exp, n_stb);
        end
    endtask

    // Block start in the model: clamp (R7), add fraction, carry (R3).
    task automatic model_reload();
        logic [16:0] s;
        int          eff;
        eff   = (p_int < 16'd2) ? 2 : int'(p_int);
        s     = {1'b0, m_acc} + {1'b0, p_frac};
        m_acc = s[15:0];
        m_len = eff + int'(s[16]);
    endtask

    task automatic on_strobe();
        int pos;
        n_stb++;
        pos = (n_stb - 1) % 4;
        if (n_stb == 1)
            check(gap == m_len + 1, "R3", gap, m_len + 1);
        else if (pos == 0)
            check(gap == m_len, cur_tag, gap, m_len);
        else
            check(gap == m_len, "R4", gap, m_len);
        check(int'(stamp) == n_stb % 256, "R8", stamp, n_stb % 256);
        check(int'(seq_num) == (n_stb % 256) / 16, "R9", seq_num, (n_stb % 256) / 16);
        last_gap = gap;
        gap = 0;
        if (n_stb % 4 == 0) model_reload();
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        gap++;
        if (sample_stb) on_strobe();
    endtask

    task automatic wait_stb();
        do tick(); while (!sample_stb);
    endtask

    task automatic host_write(input logic [15:0] wi, input logic [15:0] wf);
        int_we = 1'b1; int_wdata = wi;
        frac_we = 1'b1; frac_wdata = wf;
        p_int = wi; p_frac = wf;
        tick();
        int_we = 1'b0; frac_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: outputs held at zero in reset
        repeat (3) @(negedge clk);
        check(sample_stb == 1'b0, "R1", sample_stb, 0);
        check(stamp == 8'd0, "R1", stamp, 0);
        check(seq_num == 4'd0, "R1", seq_num, 0);
        rst_n = 1'b1;
        m_acc = '0; p_int = 16'(RST_INT); p_frac = '0;
        model_reload();
        gap = 0;
        tick();
        check(sample_stb == 1'b0 && stamp == 8'd0 && seq_num == 4'd0, "R1", stamp, 0);

        // R5: mid-block write keeps the old spacing for the rest of the block
        wait_stb();
        host_write(16'd3, 16'h0000);
        wait_stb();
        check(last_gap == RST_INT, "R5", last_gap, RST_INT);
        repeat (6) wait_stb();

        // Table of period vectors, each written one cycle after a strobe
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] vi;
            logic [15:0] vf;
            int          nb;
            vi = VECS[i][39:24];
            vf = VECS[i][23:8];
            nb = int'(VECS[i][7:0]);
            wait_stb();
            cur_tag = (vi < 16'd2) ? "R7" : "R3";
            host_write(vi, vf);
            repeat (nb * 4) wait_stb();
        end

        // R6: accumulator carries across fraction changes
        cur_tag = "R6";
        wait_stb();
        host_write(16'd4, 16'hA000);
        repeat (5) wait_stb();
        host_write(16'd4, 16'h7000);
        repeat (12) wait_stb();
        host_write(16'd6, 16'hF000);
        repeat (12) wait_stb();

        // R8/R9: timestamp wrap at minimum period
        cur_tag = "R3";
        host_write(16'd2, 16'h0000);
        while (n_stb < 300) wait_stb();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule